// File: doc/BRIEF.md
# Write-Protected Calendar Clock

This block keeps wall-clock time in plain binary fields: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A free-running prescaler divides the system clock by the parameter `TICK_DIV` and produces one advance per second. Each advance ripples through the fields with the usual carries, including month lengths and a leap rule under which every year divisible by four has a 29th of February.

Software reaches the clock through a small single-cycle register bus. Every field can be read back. Each field write must be armed by a write to a dedicated unlock address in the bus access directly before it. An unarmed write is dropped without effect. A control address lets software restart the prescaler, so the next second begins a full period later. A write to the seconds field does the same, which makes a freshly set time start on a clean second boundary.

Address map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control, 8 unlock.

Top module: `cal_rtc`

## Requirements
- R1: Seconds and minutes each count 0 to 59. When a second advance finds seconds at 59, seconds return to 0 and minutes advance. Minutes at 59 return to 0 and carry into the hour.
- R2: Hours count 0 to 23, with 0 meaning midnight. On the carry from 23 to 0, the day of week and the date advance together.
- R3: The day of week counts 1 to 7, with 1 meaning Sunday, and 7 is followed by 1.
- R4: The date runs from 1 up to the month's length, and then returns to 1 with a month carry. Month lengths are 31, 28 or 29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 1 to 12. Month 12 is followed by month 1 with a year carry.
- R5: The year counts 0 to 99, and 99 is followed by 0. A year whose value is divisible by 4 (0 included) gives February 29 days.
- R6: A write to addresses 0 to 6 changes its field only when the bus access immediately before it was a write to address 8. Otherwise the field keeps its value.
- R7: One unlock arms exactly one field write. A read, or a write to any address other than 8, clears the unlock. Cycles with no bus access leave it unchanged.
- R8: A write to address 7 with bit 0 set restarts the prescaler without any unlock. The next second advance then comes exactly `TICK_DIV` clock edges after the edge that took the write.
- R9: An accepted write to the seconds field also restarts the prescaler. The next advance comes `TICK_DIV` edges after that write.
- R10: If a second advance falls on the edge of an accepted field write, the advance is dropped. The written field takes the new value and every other field keeps its old value.
- R11: A read at address A presents its data on `bus_rdata` from the edge that takes the read. The data is the field value held just before that edge, in its low bits with zeros above. Addresses 7 and 8 read as 0.
- R12: Synchronous reset sets the time to 00:00:00, day of week 1, date 1, month 1 and year 0, and clears the unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
On every cycle, the assertions check the following:
- seconds wrap to 0 and the hour, day-of-week and leap-day carries;
- arming by the unlock address, and its clearing by any other access;
- the time holding still under an unarmed write;
- the prescaler returning to its start after either kind of restart;
- the seconds field holding when an advance meets a write to another field.

Only the bench scenarios can show that whole multi-second runs land on the right calendar date, and that the restart moves the second boundary by the right number of cycles. They also cover the read-back latency and the reset values seen through the bus.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_SEC    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN    = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_HR     = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_DOW    = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_DATE   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_MON    = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_YR     = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_UNLOCK = 4'd8;

  typedef struct packed {
    logic [7:0] yr;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{yr: 8'd0, mon: 4'd1, date: 5'd1,
                                       dow: 3'd1, hr: 5'd0, min: 6'd0,
                                       sec: 6'd0};

  function automatic logic [4:0] month_days(input logic [3:0] mon,
                                            input logic [7:0] yr);
    logic [4:0] d;
    case (mon)
      4'd2:                      d = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
      default:                   d = 5'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick,
  output logic at_start
);

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick     = (cnt_q == LAST) && !restart;
      assign at_start = (cnt_q == '0);
    end else begin : g_pass
      assign tick     = !restart;
      assign at_start = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output rtc_time_t  now_q
);

  rtc_time_t nxt;
  logic      end_of_month;

  assign end_of_month = (now_q.date >= month_days(now_q.mon, now_q.yr));

  always_comb begin
    nxt = now_q;
    if (now_q.sec >= 6'd59) begin
      nxt.sec = 6'd0;
      if (now_q.min >= 6'd59) begin
        nxt.min = 6'd0;
        if (now_q.hr >= 5'd23) begin
          nxt.hr  = 5'd0;
          nxt.dow = (now_q.dow >= 3'd7) ? 3'd1 : now_q.dow + 3'd1;
          if (end_of_month) begin
            nxt.date = 5'd1;
            if (now_q.mon >= 4'd12) begin
              nxt.mon = 4'd1;
              nxt.yr  = (now_q.yr >= 8'd99) ? 8'd0 : now_q.yr + 8'd1;
            end else begin
              nxt.mon = now_q.mon + 4'd1;
            end
          end else begin
            nxt.date = now_q.date + 5'd1;
          end
        end else begin
          nxt.hr = now_q.hr + 5'd1;
        end
      end else begin
        nxt.min = now_q.min + 6'd1;
      end
    end else begin
      nxt.sec = now_q.sec + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q <= TIME_RESET;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0:    now_q.sec  <= wr_data[5:0];
        3'd1:    now_q.min  <= wr_data[5:0];
        3'd2:    now_q.hr   <= wr_data[4:0];
        3'd3:    now_q.dow  <= wr_data[2:0];
        3'd4:    now_q.date <= wr_data[4:0];
        3'd5:    now_q.mon  <= wr_data[3:0];
        default: now_q.yr   <= wr_data;
      endcase
    end else if (tick) begin
      now_q <= nxt;
    end
  end

endmodule

// File: rtl/rtc_regbus.sv
module rtc_regbus
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  rtc_time_t         now,
  output logic              wr_en,
  output logic [2:0]        wr_sel,
  output logic [7:0]        wr_data,
  output logic              restart,
  output logic              armed_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic              is_time;
  logic              do_write;
  logic [DATA_W-1:0] rd_val;

  assign is_time  = (bus_addr <= ADR_YR);
  assign do_write = bus_en && bus_wr;
  assign wr_en    = do_write && is_time && armed_q;
  assign wr_sel   = bus_addr[2:0];
  assign wr_data  = bus_wdata;
  assign restart  = (do_write && (bus_addr == ADR_CTRL) && bus_wdata[0]) ||
                    (wr_en && (bus_addr == ADR_SEC));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (bus_en) begin
      armed_q <= bus_wr && (bus_addr == ADR_UNLOCK);
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      ADR_SEC:  rd_val = DATA_W'(now.sec);
      ADR_MIN:  rd_val = DATA_W'(now.min);
      ADR_HR:   rd_val = DATA_W'(now.hr);
      ADR_DOW:  rd_val = DATA_W'(now.dow);
      ADR_DATE: rd_val = DATA_W'(now.date);
      ADR_MON:  rd_val = DATA_W'(now.mon);
      ADR_YR:   rd_val = DATA_W'(now.yr);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_en && !bus_wr) begin
      rdata_q <= rd_val;
    end
  end

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  rtc_time_t  now_q;
  logic       tick;
  logic       presc_at_start;
  logic       wr_acc;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic       restart;
  logic       armed;

  rtc_regbus u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .now       (now_q),
    .wr_en     (wr_acc),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .restart   (restart),
    .armed_q   (armed),
    .rdata_q   (bus_rdata)
  );

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .tick     (tick),
    .at_start (presc_at_start)
  );

  rtc_calendar u_cal (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (wr_acc),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .now_q   (now_q)
  );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input rtc_time_t         now_q,
  input logic              tick,
  input logic              wr_acc,
  input logic              armed,
  input logic              presc_at_start
);

  logic adv, hour_roll;
  assign adv       = tick && !wr_acc;
  assign hour_roll = adv && now_q.sec == 6'd59 && now_q.min == 6'd59 &&
                     now_q.hr == 5'd23;

  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    adv && now_q.sec == 6'd59 |=> now_q.sec == 6'd0);

  assert_hour_carry_R2: assert property (@(posedge clk) disable iff (rst)
    hour_roll |=> now_q.hr == 5'd0 && now_q.dow != $past(now_q.dow));

  assert_dow_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    hour_roll && now_q.dow == 3'd7 |=> now_q.dow == 3'd1);

  assert_leap_day_R5: assert property (@(posedge clk) disable iff (rst)
    hour_roll && now_q.mon == 4'd2 && now_q.date == 5'd28 &&
    now_q.yr[1:0] == 2'b00 |=> now_q.date == 5'd29);

  assert_locked_write_R6: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_wr && bus_addr <= ADR_YR && !armed && !tick
    |=> $stable(now_q));

  assert_arm_set_R7: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_wr && bus_addr == ADR_UNLOCK |=> armed);

  assert_arm_clear_R7: assert property (@(posedge clk) disable iff (rst)
    bus_en && !(bus_wr && bus_addr == ADR_UNLOCK) |=> !armed);

  assert_ctrl_restart_R8: assert property (@(posedge clk) disable iff (rst)
    bus_en && bus_wr && bus_addr == ADR_CTRL && bus_wdata[0]
    |=> presc_at_start);

  assert_sec_restart_R9: assert property (@(posedge clk) disable iff (rst)
    wr_acc && bus_addr == ADR_SEC |=> presc_at_start);

  assert_tick_drop_R10: assert property (@(posedge clk) disable iff (rst)
    wr_acc && tick && bus_addr != ADR_SEC |=> $stable(now_q.sec));

endmodule

bind cal_rtc rtc_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_en         (bus_en),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .now_q          (now_q),
  .tick           (tick),
  .wr_acc         (wr_acc),
  .armed          (armed),
  .presc_at_start (presc_at_start)
);

// File: tb/sim_cal_rtc.sv
`timescale 1ns/1ps
module sim_cal_rtc;

  localparam int DIV = 16;
  localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd1, A_HR = 4'd2, A_DOW = 4'd3,
                         A_DATE = 4'd4, A_MON = 4'd5, A_YR = 4'd6,
                         A_CTRL = 4'd7, A_UNL = 4'd8;

  typedef struct {
    int sec; int min; int hr; int dow; int date; int mon; int yr;
  } tm_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  cal_rtc #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t step(tm_t t);
    tm_t r = t;
    r.sec = t.sec + 1;
    if (r.sec == 60) begin
      r.sec = 0; r.min = t.min + 1;
      if (r.min == 60) begin
        r.min = 0; r.hr = t.hr + 1;
        if (r.hr == 24) begin
          r.hr = 0;
          r.dow = (t.dow == 7) ? 1 : t.dow + 1;
          r.date = t.date + 1;
          if (r.date > mdays(t.mon, t.yr)) begin
            r.date = 1; r.mon = t.mon + 1;
            if (r.mon == 13) begin
              r.mon = 1;
              r.yr = (t.yr == 99) ? 0 : t.yr + 1;
            end
          end
        end
      end
    end
    return r;
  endfunction

  task automatic check(int act, int exp, string req, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic set_field(logic [3:0] a, int v);
    wr(A_UNL, 8'h00);
    wr(a, 8'(v));
  endtask

  // seconds written last: the prescaler restarts on that edge (R9)
  task automatic set_time(tm_t t);
    set_field(A_SEC, 0);
    set_field(A_MIN, t.min);
    set_field(A_HR, t.hr);
    set_field(A_DOW, t.dow);
    set_field(A_DATE, t.date);
    set_field(A_MON, t.mon);
    set_field(A_YR, t.yr);
    set_field(A_SEC, t.sec);
  endtask

  task automatic check_time(tm_t e, string req);
    int v;
    rd(A_SEC, v);  check(v, e.sec, req, "seconds");
    rd(A_MIN, v);  check(v, e.min, req, "minutes");
    rd(A_HR, v);   check(v, e.hr, req, "hours");
    rd(A_DOW, v);  check(v, e.dow, req, "day of week");
    rd(A_DATE, v); check(v, e.date, req, "date");
    rd(A_MON, v);  check(v, e.mon, req, "month");
    rd(A_YR, v);   check(v, e.yr, req, "year");
  endtask

  task automatic run_case(tm_t t, int k, string req);
    tm_t e = t;
    set_time(t);
    repeat (k * DIV) @(negedge clk);
    for (int i = 0; i < k; i++) e = step(e);
    check_time(e, req);
  endtask

  function automatic tm_t mk(int s, int mi, int h, int dw, int dt, int mo, int y);
    tm_t t;
    t.sec = s; t.min = mi; t.hr = h; t.dow = dw; t.date = dt; t.mon = mo; t.yr = y;
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v;
    tm_t t;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R12 reset state, R11 read path
    check_time(mk(0, 0, 0, 1, 1, 1, 0), "R12");
    rd(A_CTRL, v); check(v, 0, "R11", "control reads zero");
    rd(A_UNL, v);  check(v, 0, "R11", "unlock reads zero");

    // R1 R2 R3 R4 R5 directed rollovers
    run_case(mk(58, 59, 22, 3, 10, 6, 50), 2, "R1");
    run_case(mk(59, 59, 23, 7, 15, 3, 41), 1, "R2 R3");
    run_case(mk(59, 59, 23, 2, 30, 4, 7), 1, "R4");
    run_case(mk(59, 59, 23, 5, 28, 2, 24), 1, "R5 leap");
    run_case(mk(59, 59, 23, 5, 28, 2, 23), 1, "R5 common");
    run_case(mk(59, 59, 23, 1, 28, 2, 0), 1, "R5 year0");
    run_case(mk(59, 59, 23, 6, 31, 12, 99), 1, "R5 R4 century");

    // R6: write without unlock is ignored
    set_time(mk(10, 5, 3, 2, 2, 2, 2));
    wr(A_MIN, 8'd40);
    rd(A_MIN, v); check(v, 5, "R6", "unarmed minute write");
    // R7: a read between unlock and write clears the unlock
    wr(A_UNL, 8'h00); rd(A_SEC, v); wr(A_HR, 8'd9);
    rd(A_HR, v); check(v, 3, "R7", "unlock cleared by read");
    // R7: one unlock arms exactly one write
    wr(A_UNL, 8'h00); wr(A_MIN, 8'd33); wr(A_HR, 8'd11);
    rd(A_MIN, v); check(v, 33, "R7", "armed write accepted");
    rd(A_HR, v);  check(v, 3, "R7", "second write rejected");
    // R7: idle cycles keep the unlock
    wr(A_UNL, 8'h00); @(negedge clk); @(negedge clk); wr(A_DOW, 8'd6);
    rd(A_DOW, v); check(v, 6, "R7", "unlock kept over idle");

    // R9: seconds write restarts the second
    set_time(mk(20, 1, 1, 1, 1, 1, 1));
    repeat (DIV - 1) @(negedge clk);
    rd(A_SEC, v); check(v, 20, "R9", "just before tick");
    rd(A_SEC, v); check(v, 21, "R9", "just after tick");

    // R8: control restart moves the next tick
    set_time(mk(5, 1, 1, 1, 1, 1, 1));
    repeat (9) @(negedge clk);
    wr(A_CTRL, 8'h01);
    repeat (9) @(negedge clk);
    rd(A_SEC, v); check(v, 5, "R8", "old boundary skipped");
    repeat (6) @(negedge clk);
    rd(A_SEC, v); check(v, 6, "R8", "new boundary");

    // R10: tick meeting a minute write is dropped
    set_time(mk(30, 10, 1, 1, 1, 1, 1));
    repeat (DIV - 2) @(negedge clk);
    set_field(A_MIN, 20);
    rd(A_SEC, v); check(v, 30, "R10", "seconds held");
    rd(A_MIN, v); check(v, 20, "R10", "minute written");

    // random near-rollover cases over R1..R5
    for (int it = 0; it < 24; it++) begin
      t.yr   = $urandom_range(99, 0);
      t.mon  = $urandom_range(12, 1);
      t.date = mdays(t.mon, t.yr) - $urandom_range(1, 0);
      t.hr   = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
      t.min  = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
      t.sec  = $urandom_range(59, 50);
      t.dow  = $urandom_range(7, 1);
      run_case(t, $urandom_range(10, 1), "R1 R2 R3 R4 R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule